// File: doc/BRIEF.md
# Banked Control-Bit Write Decoder

This block is the control-register front end of a character display terminal. The host reaches it through a bit-addressed serial I/O path. Each access carries a bit address, one data bit and a write strobe. Only the upper half of the address space belongs to the block, which is addresses 8 to 15 at the default width. The top address holds a bank-select (word-select) latch. Its value decides which of two sets of functions the shared addresses reach.

Each accepted write does two things. It produces a one-clock, active-low strobe on the output slot for that address, and it updates the single-bit control latch that the address and the current bank name. The decode always uses the bank value from before the write. The block also keeps a previous-state flag. When the host writes a 1 to the bank latch, the flag records the bank value that was there before. The host can read the flag back at the top address. A low chip-select enables the block. While chip-select is high, writes have no effect and all strobes stay high.

Top module: `term_ctl_decoder`

## Requirements
- R1: After reset, all control latches, the bank latch and the previous-state flag read 0, every bit of `dec_stb_no` is 1, and `rdata_o` is 0.
- R2: While `sel_ni` is 1, writes change no latch and no strobe, and `rdata_o` is 0.
- R3: Writes to addresses 0 to 7 have no effect. Addresses 9 and 11 never pulse their slot (`dec_stb_no[1]` and `dec_stb_no[3]`) in either bank.
- R4: A write to address 8 in bank 0 drives `dec_stb_no[0]` low. The same write in bank 1 produces no strobe.
- R5: A write to address 10 drives `dec_stb_no[2]` low in both banks. This is the cursor-move strobe, and it also requests a refresh-memory read.
- R6: In bank 0, addresses 12, 13 and 14 load the data bit into `kbd_irq_en_o`, `dual_int_en_o` and `disp_en_o`, and pulse slots 4, 5 and 6.
- R7: In bank 1, addresses 12, 13 and 14 load the data bit into `cursor_en_o`, `kbd_ack_o` and `beep_en_o`. The bank-0 latches are left unchanged.
- R8: A write to address 15 loads `word_sel_o` (bank 0 = 0, bank 1 = 1) in either bank and pulses slot 7.
- R9: Writing 1 to address 15 loads the previous-state flag with the `word_sel_o` value from before the write. Writing 0 to address 15 leaves the flag unchanged.
- R10: `rdata_o` shows the previous-state flag when `sel_ni` is 0 and `addr_i` is 15. At every other address it is 0.
- R11: A strobe goes low in the cycle after the edge that accepts the write. It lasts exactly one clock, and at most one slot is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, also the host clear of the flag |
| sel_ni | input | 1 | Active-low chip select |
| addr_i | input | 4 | Bit address for writes and reads |
| wdata_i | input | 1 | Data bit for writes |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| dec_stb_no | output | 8 | Active-low strobe pulses, slot i is address 8+i |
| kbd_irq_en_o | output | 1 | Keyboard interrupt enable (bank 0, address 12) |
| dual_int_en_o | output | 1 | Dual intensity enable (bank 0, address 13) |
| disp_en_o | output | 1 | Display enable (bank 0, address 14) |
| cursor_en_o | output | 1 | Cursor display enable (bank 1, address 12) |
| kbd_ack_o | output | 1 | Keyboard acknowledge (bank 1, address 13) |
| beep_en_o | output | 1 | Beep enable (bank 1, address 14) |
| word_sel_o | output | 1 | Bank-select latch |
| rdata_o | output | 1 | Read data |

## Verification
The bench builds the block with its default 4-bit address. This keeps the whole address space small enough to write every address in both banks. Each write to a shared address is checked against a bank-dependent model. The bench checks the strobe in the pulse cycle and again in the cycle after it. It drives the bank latch through 0→1, 1→1 and 1→0 so that the previous-state flag can be seen to capture and to hold.

// File: rtl/term_ctl_pkg.sv
package term_ctl_pkg;
  localparam int SLOT_W = 3;
  localparam int N_SLOT = 1 << SLOT_W;
  localparam int N_CTL_BANK = 3;
  localparam int N_BANK = 2;
  localparam int N_CTL = N_CTL_BANK * N_BANK;

  // slot = address offset within the decoded window
  localparam logic [SLOT_W-1:0] SLOT_WDATA = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_CMOVE = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_CTL0  = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_WSEL  = 3'd7;

  typedef enum logic {BANK_LO = 1'b0, BANK_HI = 1'b1} bank_e;

  function automatic logic slot_has_stb(logic [SLOT_W-1:0] slot, bank_e bank);
    case (slot)
      SLOT_WDATA: return bank == BANK_LO;
      SLOT_CMOVE: return 1'b1;
      3'd4, 3'd5, 3'd6, SLOT_WSEL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/term_ctl_addr_dec.sv
module term_ctl_addr_dec
  import term_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bank_e             bank_i,
  output logic [N_SLOT-1:0] stb_req_o,
  output logic [N_CTL-1:0]  ctl_we_o,
  output logic              wsel_we_o,
  output logic              wsel_rd_o
);
  localparam int N_ADDR = 1 << ADDR_W;
  localparam int BASE   = N_ADDR - N_SLOT;

  logic              in_win;
  logic              go;
  logic [SLOT_W-1:0] slot;

  assign in_win = int'(addr_i) >= BASE;
  assign slot   = SLOT_W'(int'(addr_i) - BASE);
  assign go     = wr_i && !sel_ni && in_win;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_stb
    assign stb_req_o[s] = go && (slot == SLOT_W'(s)) && slot_has_stb(SLOT_W'(s), bank_i);
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    for (genvar k = 0; k < N_CTL_BANK; k++) begin : g_ctl
      assign ctl_we_o[b*N_CTL_BANK+k] = go && (bank_i == bank_e'(b))
                                        && (slot == SLOT_CTL0 + SLOT_W'(k));
    end
  end

  assign wsel_we_o = go && slot == SLOT_WSEL;
  assign wsel_rd_o = !sel_ni && in_win && slot == SLOT_WSEL;
endmodule

// File: rtl/term_ctl_strobe_gen.sv
module term_ctl_strobe_gen
  import term_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic [N_SLOT-1:0] stb_req_i,
  output logic [N_SLOT-1:0] stb_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_no <= '1;
    else         stb_no <= ~stb_req_i;
  end

  // R2
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_ni) |-> &stb_no);
  // R11
  one_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~stb_no));
  // R3
  dead_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_no[1] && stb_no[3]);
  // R11
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_no != '1) |=> (stb_no != $past(stb_no)));
endmodule

// File: rtl/term_ctl_latches.sv
module term_ctl_latches
  import term_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdata_i,
  input  logic [N_CTL-1:0] ctl_we_i,
  input  logic             wsel_we_i,
  output logic [N_CTL-1:0] ctl_q_o,
  output logic             wsel_q_o,
  output logic             prev_q_o
);
  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ctl_q_o[i] <= 1'b0;
      else if (ctl_we_i[i]) ctl_q_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q_o <= 1'b0;
      prev_q_o <= 1'b0;
    end else if (wsel_we_i) begin
      wsel_q_o <= wdata_i;
      if (wdata_i) prev_q_o <= wsel_q_o; // keep value seen before the set
    end
  end

  // R8
  wsel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wsel_we_i) |-> $stable(wsel_q_o));
  // R9
  prev_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel_we_i && wdata_i) |=> prev_q_o == $past(wsel_q_o));
  // R9
  prev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wsel_we_i && wdata_i) |=> $stable(prev_q_o));
  // R7
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i == '0) |=> $stable(ctl_q_o));
endmodule

// File: rtl/term_ctl_decoder.sv
module term_ctl_decoder
  import term_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic              wr_i,
  output logic [N_SLOT-1:0] dec_stb_no,
  output logic              kbd_irq_en_o,
  output logic              dual_int_en_o,
  output logic              disp_en_o,
  output logic              cursor_en_o,
  output logic              kbd_ack_o,
  output logic              beep_en_o,
  output logic              word_sel_o,
  output logic              rdata_o
);
  logic [N_SLOT-1:0] stb_req;
  logic [N_CTL-1:0]  ctl_we;
  logic [N_CTL-1:0]  ctl_q;
  logic              wsel_we;
  logic              wsel_rd;
  logic              prev_q;

  term_ctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel_ni    (sel_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .bank_i    (bank_e'(word_sel_o)),
    .stb_req_o (stb_req),
    .ctl_we_o  (ctl_we),
    .wsel_we_o (wsel_we),
    .wsel_rd_o (wsel_rd)
  );

  term_ctl_strobe_gen u_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_ni    (sel_ni),
    .stb_req_i (stb_req),
    .stb_no    (dec_stb_no)
  );

  term_ctl_latches u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .ctl_we_i  (ctl_we),
    .wsel_we_i (wsel_we),
    .ctl_q_o   (ctl_q),
    .wsel_q_o  (word_sel_o),
    .prev_q_o  (prev_q)
  );

  // bank 0 set occupies ctl_q[2:0], bank 1 set ctl_q[5:3]
  assign kbd_irq_en_o  = ctl_q[0];
  assign dual_int_en_o = ctl_q[1];
  assign disp_en_o     = ctl_q[2];
  assign cursor_en_o   = ctl_q[3];
  assign kbd_ack_o     = ctl_q[4];
  assign beep_en_o     = ctl_q[5];
  assign rdata_o       = wsel_rd & prev_q;

  // R10
  rd_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni || addr_i != {ADDR_W{1'b1}}) |-> !rdata_o);
  // R3
  low_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |=> (dec_stb_no == '1 && $stable(ctl_q) && $stable(word_sel_o)));
endmodule

// File: tb/tb_term_ctl_decoder.sv
module tb_term_ctl_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_ni = 1'b1;
  logic [3:0] addr_i = '0;
  logic       wdata_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] dec_stb_no;
  logic kbd_irq_en_o, dual_int_en_o, disp_en_o, cursor_en_o, kbd_ack_o, beep_en_o;
  logic word_sel_o, rdata_o;

  int total = 0;
  int bad = 0;
  logic [5:0] m_ctl;  // kbd_irq, dual, disp, cursor, ack, beep
  logic       m_ws, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_ctl_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .dec_stb_no(dec_stb_no),
    .kbd_irq_en_o(kbd_irq_en_o), .dual_int_en_o(dual_int_en_o),
    .disp_en_o(disp_en_o), .cursor_en_o(cursor_en_o), .kbd_ack_o(kbd_ack_o),
    .beep_en_o(beep_en_o), .word_sel_o(word_sel_o), .rdata_o(rdata_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ctl_now();
    return {beep_en_o, kbd_ack_o, cursor_en_o, disp_en_o, dual_int_en_o, kbd_irq_en_o};
  endfunction

  task automatic chk_state(string req);
    chk(req, {8'h0, ctl_now()}, {8'h0, m_ctl});
    chk(req, {15'h0, word_sel_o}, {15'h0, m_ws});
  endtask

  // write, check pulse cycle, then check pulse is gone
  task automatic wr(logic [3:0] a, logic d, logic sel, logic [7:0] exp_stb, string req);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1; sel_ni = sel;
    @(posedge clk); #1;
    chk(req, {8'h0, dec_stb_no}, {8'h0, exp_stb});
    @(negedge clk);
    wr_i = 1'b0; sel_ni = 1'b0;
    @(posedge clk); #1;
    chk("R11", {8'h0, dec_stb_no}, 16'h00ff);
  endtask

  task automatic rd(logic [3:0] a, logic sel, logic exp, string req);
    @(negedge clk);
    addr_i = a; sel_ni = sel; #1;
    chk(req, {15'h0, rdata_o}, {15'h0, exp});
    sel_ni = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; sel_ni = 1'b0; wr_i = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    m_ctl = '0; m_ws = 1'b0; m_prev = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R1");
    chk("R1", {8'h0, dec_stb_no}, 16'h00ff);
    rd(4'd15, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_sel_high();
    wr(4'd12, 1'b1, 1'b1, 8'hff, "R2");
    wr(4'd15, 1'b1, 1'b1, 8'hff, "R2");
    wr(4'd8, 1'b1, 1'b1, 8'hff, "R2");
    chk_state("R2");
    rd(4'd15, 1'b1, 1'b0, "R2");
  endtask

  task automatic t_low_addr();
    for (int a = 0; a < 8; a++) wr(4'(a), 1'b1, 1'b0, 8'hff, "R3");
    chk_state("R3");
    wr(4'd9, 1'b1, 1'b0, 8'hff, "R3");
    wr(4'd11, 1'b1, 1'b0, 8'hff, "R3");
    chk_state("R3");
  endtask

  task automatic t_bank0();
    wr(4'd8, 1'b1, 1'b0, 8'hfe, "R4");
    wr(4'd10, 1'b0, 1'b0, 8'hfb, "R5");
    wr(4'd12, 1'b1, 1'b0, 8'hef, "R6"); m_ctl[0] = 1'b1;
    wr(4'd13, 1'b1, 1'b0, 8'hdf, "R6"); m_ctl[1] = 1'b1;
    wr(4'd14, 1'b1, 1'b0, 8'hbf, "R6"); m_ctl[2] = 1'b1;
    chk_state("R6");
    wr(4'd13, 1'b0, 1'b0, 8'hdf, "R6"); m_ctl[1] = 1'b0;
    chk_state("R6");
  endtask

  task automatic t_wsel_set();
    wr(4'd15, 1'b1, 1'b0, 8'h7f, "R8"); m_prev = m_ws; m_ws = 1'b1;
    chk_state("R8");
    rd(4'd15, 1'b0, 1'b0, "R9");
    wr(4'd15, 1'b1, 1'b0, 8'h7f, "R8"); m_prev = m_ws;
    rd(4'd15, 1'b0, 1'b1, "R9");
    rd(4'd14, 1'b0, 1'b0, "R10");
    rd(4'd15, 1'b1, 1'b0, "R10");
  endtask

  task automatic t_bank1();
    wr(4'd8, 1'b1, 1'b0, 8'hff, "R4");
    wr(4'd10, 1'b1, 1'b0, 8'hfb, "R5");
    wr(4'd9, 1'b1, 1'b0, 8'hff, "R3");
    wr(4'd11, 1'b1, 1'b0, 8'hff, "R3");
    wr(4'd12, 1'b1, 1'b0, 8'hef, "R7"); m_ctl[3] = 1'b1;
    wr(4'd13, 1'b1, 1'b0, 8'hdf, "R7"); m_ctl[4] = 1'b1;
    wr(4'd14, 1'b1, 1'b0, 8'hbf, "R7"); m_ctl[5] = 1'b1;
    chk_state("R7");
    wr(4'd12, 1'b0, 1'b0, 8'hef, "R7"); m_ctl[3] = 1'b0;
    chk_state("R7");
  endtask

  task automatic t_wsel_clear();
    wr(4'd15, 1'b0, 1'b0, 8'h7f, "R8"); m_ws = 1'b0;
    chk_state("R8");
    rd(4'd15, 1'b0, m_prev, "R9");
    wr(4'd14, 1'b0, 1'b0, 8'hbf, "R6"); m_ctl[2] = 1'b0;
    chk_state("R6");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_sel_high();
    t_low_addr();
    t_bank0();
    t_wsel_set();
    t_bank1();
    t_wsel_clear();
    do_reset();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule